// File: doc/BRIEF.md
# Control Endpoint Mode and Count Register Interlock

This block holds the two registers that a USB device's control endpoint shares between its serial interface engine and the CPU. The first is an 8-bit mode/status register. Its upper nibble carries four transaction flags and its lower nibble carries the endpoint mode. The second is a byte-count register. Both agents may write either register. When the engine writes a register, that register locks, and firmware cannot overwrite it until firmware has read it. This keeps freshly posted status from being lost.

The block also gates CPU writes into the endpoint data FIFO. While a SETUP packet is pending, its data could be overwritten, so the gate stays closed for that whole time. The engine is represented by single-cycle event and update strobes, plus one level input. That level input is high from the start of a SETUP data packet until the end of the data phase of a control write.

Top module: `ep_ctl_interlock`

## Requirements
- R1: After reset both registers read 0x00, both locks are clear and `fifo_wr_en` is low.
- R2: In the mode register, bit 7 is SETUP-seen, bit 6 is IN-acked, bit 5 is OUT-done, bit 4 is ACK-seen and bits 3:0 are the mode. `sie_setup_rx` sets bit 7, `sie_out_acked` sets bit 5 and `sie_txn_acked` sets bit 4. A flag that is already set stays set.
- R3: Only `sie_in_acked` sets bit 6. A transaction that was acknowledged but is not an acknowledged IN leaves bit 6 unchanged.
- R4: Any engine strobe aimed at a register locks that register. While a register is locked, CPU writes to it have no effect.
- R5: A CPU read of a register releases that register's lock at the next clock edge. The mode lock and the count lock are independent of each other. `cpu_sel` = 0 selects the mode register and 1 selects the count register.
- R6: An unlocked CPU write to the mode register clears bits 7:4, whatever data is written, and loads bits 3:0 from `cpu_wdata[3:0]`.
- R7: While `sie_setup_pin` is high, bit 7 reads 1 and no CPU write can clear it.
- R8: `fifo_wr_en` is low whenever bit 7 is 1. Otherwise it follows `cpu_fifo_wr`.
- R9: If an engine strobe and a CPU write hit the same register in the same cycle, the engine update applies, the CPU write is dropped and the register ends up locked.
- R10: `sie_mode_we` replaces bits 3:0 with `sie_mode` and keeps the flags.
- R11: `sie_cnt_we` loads the count from `sie_cnt` and locks the count register. An unlocked CPU write loads the count from `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register select: 0 = mode, 1 = count |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register contents |
| cpu_fifo_wr | input | 1 | CPU request to write the endpoint FIFO |
| fifo_wr_en | output | 1 | Gated FIFO write enable |
| sie_setup_rx | input | 1 | Valid SETUP received strobe |
| sie_setup_pin | input | 1 | SETUP data / control-write data phase in progress |
| sie_in_acked | input | 1 | IN data acknowledged by host |
| sie_out_acked | input | 1 | Last OUT packet received and acknowledged |
| sie_txn_acked | input | 1 | Transaction completed with ACK |
| sie_mode_we | input | 1 | Engine mode update strobe |
| sie_mode | input | 4 | Engine mode value |
| sie_cnt_we | input | 1 | Engine count update strobe |
| sie_cnt | input | 8 | Engine count value |
| mode_q | output | 8 | Mode/status register |
| count_q | output | 8 | Count register |
| mode_locked | output | 1 | Mode register lock |
| count_locked | output | 1 | Count register lock |

## Verification
Every strobe, whether from the engine or the CPU, acts at the next rising edge, so register contents and lock bits are due one edge after the stimulus. With the default combinational gate, `fifo_wr_en` reflects bit 7 in the same cycle that bit 7 changes. Inputs change on the falling edge, and each result is sampled at the falling edge after the edge that should have produced it. A register that was expected to stay unchanged is therefore seen after the write that tried to change it and before the next stimulus.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;
   localparam int FLAG_W = 4;
   localparam int F_SETUP = 3;
   localparam int F_IN    = 2;
   localparam int F_OUT   = 1;
   localparam int F_ACK   = 0;

   typedef enum logic {
      SEL_MODE  = 1'b0,
      SEL_COUNT = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic setup;
      logic in_ack;
      logic out_ack;
      logic txn_ack;
   } sie_evt_t;
endpackage

// File: rtl/ep_lock_bit.sv
module ep_lock_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic sie_hit,
   input  logic cpu_rd_hit,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          locked <= 1'b0;
      else if (sie_hit)    locked <= 1'b1;
      else if (cpu_rd_hit) locked <= 1'b0;
   end

   // R9
   sie_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sie_hit |=> locked);
   // R5
   read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_hit && !sie_hit) |=> !locked);
endmodule

// File: rtl/ep_mode_reg.sv
module ep_mode_reg
   import ep_ctl_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter int DATA_W = MODE_W + FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_hit,
   input  logic              cpu_rd_hit,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  sie_evt_t          evt,
   input  logic              setup_pin,
   input  logic              sie_mode_we,
   input  logic [MODE_W-1:0] sie_mode,
   output logic [FLAG_W-1:0] flags,
   output logic [MODE_W-1:0] mode,
   output logic              locked
);
   logic sie_hit;
   logic cpu_apply;
   logic [FLAG_W-1:0] flag_d;
   logic [MODE_W-1:0] mode_d;

   assign sie_hit   = (|evt) | sie_mode_we;
   assign cpu_apply = cpu_wr_hit & ~locked & ~sie_hit;

   always_comb begin
      flag_d = flags;
      mode_d = mode;
      if (sie_hit) begin
         flag_d = flags | evt;
         if (sie_mode_we) mode_d = sie_mode;
      end else if (cpu_apply) begin
         flag_d = '0;
         mode_d = cpu_wdata[MODE_W-1:0];
      end
      if (setup_pin) flag_d[F_SETUP] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         mode  <= '0;
      end else begin
         flags <= flag_d;
         mode  <= mode_d;
      end
   end

   ep_lock_bit u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .sie_hit    (sie_hit),
      .cpu_rd_hit (cpu_rd_hit),
      .locked     (locked)
   );

   // R4
   locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && cpu_wr_hit && !sie_hit && !setup_pin) |=> ($stable(flags) && $stable(mode)));
   // R6
   unlocked_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && cpu_wr_hit && !sie_hit && !setup_pin)
      |=> (flags == '0 && mode == $past(cpu_wdata[MODE_W-1:0])));
   // R7
   setup_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setup_pin |=> flags[F_SETUP]);
   // R2
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sie_hit && flags[F_ACK]) |=> flags[F_ACK]);
endmodule

// File: rtl/ep_count_reg.sv
module ep_count_reg #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_hit,
   input  logic              cpu_rd_hit,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              sie_we,
   input  logic [CNT_W-1:0]  sie_val,
   output logic [CNT_W-1:0]  cnt,
   output logic              locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (sie_we)                       cnt <= sie_val;
      else if (cpu_wr_hit && !locked)        cnt <= cpu_wdata[CNT_W-1:0];
   end

   ep_lock_bit u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .sie_hit    (sie_we),
      .cpu_rd_hit (cpu_rd_hit),
      .locked     (locked)
   );

   // R4
   count_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && cpu_wr_hit && !sie_we) |=> $stable(cnt));
   // R11
   count_sie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sie_we |=> (cnt == $past(sie_val)));
endmodule

// File: rtl/ep_fifo_gate.sv
module ep_fifo_gate #(
   parameter bit GATE_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic setup_flag,
   input  logic cpu_fifo_wr,
   output logic fifo_wr_en
);
   generate
      if (GATE_REG) begin : g_reg
         logic blk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) blk_q <= 1'b0;
            else        blk_q <= setup_flag;
         end
         assign fifo_wr_en = cpu_fifo_wr & ~setup_flag & ~blk_q;
      end else begin : g_comb
         assign fifo_wr_en = cpu_fifo_wr & ~setup_flag;
      end
   endgenerate
endmodule

// File: rtl/ep_ctl_interlock.sv
module ep_ctl_interlock
   import ep_ctl_pkg::*;
#(
   parameter int MODE_W   = 4,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 8,
   parameter bit GATE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              cpu_fifo_wr,
   output logic              fifo_wr_en,
   input  logic              sie_setup_rx,
   input  logic              sie_setup_pin,
   input  logic              sie_in_acked,
   input  logic              sie_out_acked,
   input  logic              sie_txn_acked,
   input  logic              sie_mode_we,
   input  logic [MODE_W-1:0] sie_mode,
   input  logic              sie_cnt_we,
   input  logic [CNT_W-1:0]  sie_cnt,
   output logic [DATA_W-1:0] mode_q,
   output logic [CNT_W-1:0]  count_q,
   output logic              mode_locked,
   output logic              count_locked
);
   localparam int STAT_W = MODE_W + FLAG_W;

   generate
      if (STAT_W != DATA_W) begin : g_bad_mode_w
         $error("mode field plus flags must fill the data width");
      end
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cnt_w
         $error("count width must be 1..DATA_W");
      end
   endgenerate

   sie_evt_t          evt;
   logic              sel_mode, sel_cnt;
   logic [FLAG_W-1:0] flags;
   logic [MODE_W-1:0] mode;

   assign evt      = '{setup: sie_setup_rx, in_ack: sie_in_acked,
                       out_ack: sie_out_acked, txn_ack: sie_txn_acked};
   assign sel_mode = (reg_sel_e'(cpu_sel) == SEL_MODE);
   assign sel_cnt  = (reg_sel_e'(cpu_sel) == SEL_COUNT);

   ep_mode_reg #(.MODE_W(MODE_W), .DATA_W(DATA_W)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_wr_hit  (cpu_wr & sel_mode),
      .cpu_rd_hit  (cpu_rd & sel_mode),
      .cpu_wdata   (cpu_wdata),
      .evt         (evt),
      .setup_pin   (sie_setup_pin),
      .sie_mode_we (sie_mode_we),
      .sie_mode    (sie_mode),
      .flags       (flags),
      .mode        (mode),
      .locked      (mode_locked)
   );

   ep_count_reg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_wr_hit (cpu_wr & sel_cnt),
      .cpu_rd_hit (cpu_rd & sel_cnt),
      .cpu_wdata  (cpu_wdata),
      .sie_we     (sie_cnt_we),
      .sie_val    (sie_cnt),
      .cnt        (count_q),
      .locked     (count_locked)
   );

   ep_fifo_gate #(.GATE_REG(GATE_REG)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .setup_flag  (flags[F_SETUP]),
      .cpu_fifo_wr (cpu_fifo_wr),
      .fifo_wr_en  (fifo_wr_en)
   );

   assign mode_q = {flags, mode};

   always_comb begin
      cpu_rdata = '0;
      if (sel_mode) cpu_rdata = mode_q;
      else          cpu_rdata[CNT_W-1:0] = count_q;
   end

   // R8
   fifo_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[DATA_W-1] |-> !fifo_wr_en);
   // R3
   in_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sie_in_acked && !mode_q[DATA_W-2]) |=> !mode_q[DATA_W-2]);
   // R5
   lock_independent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && sel_cnt && mode_locked && !sie_cnt_we) |=> mode_locked);
endmodule

// File: tb/ep_ctl_interlock_test.sv
module ep_ctl_interlock_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       cpu_fifo_wr = 1'b0;
   logic       fifo_wr_en;
   logic       sie_setup_rx = 1'b0, sie_setup_pin = 1'b0, sie_in_acked = 1'b0;
   logic       sie_out_acked = 1'b0, sie_txn_acked = 1'b0;
   logic       sie_mode_we = 1'b0, sie_cnt_we = 1'b0;
   logic [3:0] sie_mode = '0;
   logic [7:0] sie_cnt = '0;
   logic [7:0] mode_q, count_q;
   logic       mode_locked, count_locked;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ep_ctl_interlock uut (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_fifo_wr(cpu_fifo_wr),
      .fifo_wr_en(fifo_wr_en), .sie_setup_rx(sie_setup_rx), .sie_setup_pin(sie_setup_pin),
      .sie_in_acked(sie_in_acked), .sie_out_acked(sie_out_acked),
      .sie_txn_acked(sie_txn_acked), .sie_mode_we(sie_mode_we), .sie_mode(sie_mode),
      .sie_cnt_we(sie_cnt_we), .sie_cnt(sie_cnt), .mode_q(mode_q), .count_q(count_q),
      .mode_locked(mode_locked), .count_locked(count_locked)
   );

   typedef struct packed {
      logic       sel, wr, rd;
      logic [7:0] wd;
      logic [3:0] ev;   // setup, in, out, ack
      logic       mwe;
      logic [3:0] mv;
      logic       cwe;
      logic [7:0] cv;
      logic       pin;
      logic [7:0] em, ec;
      logic       ml, cl;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b0,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h00,8'h00,1'b0,1'b0, 8'd1},  // R1 idle
      '{1'b0,1'b0,1'b0,8'h00,4'b0101,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h50,8'h00,1'b1,1'b0, 8'd3},  // R3 IN acked
      '{1'b0,1'b1,1'b0,8'hFF,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h50,8'h00,1'b1,1'b0, 8'd4},  // R4 locked write
      '{1'b0,1'b0,1'b1,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h50,8'h00,1'b0,1'b0, 8'd5},  // R5 read unlocks
      '{1'b0,1'b1,1'b0,8'hA3,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h03,8'h00,1'b0,1'b0, 8'd6},  // R6 clear flags
      '{1'b0,1'b0,1'b0,8'h00,4'b0011,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h33,8'h00,1'b1,1'b0, 8'd2},  // R2 OUT + ACK
      '{1'b1,1'b0,1'b1,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h33,8'h00,1'b1,1'b0, 8'd5},  // R5 count read keeps mode lock
      '{1'b0,1'b0,1'b1,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h33,8'h00,1'b0,1'b0, 8'd5},  // R5
      '{1'b0,1'b1,1'b0,8'h05,4'b0000,1'b1,4'h9,1'b0,8'h00,1'b0, 8'h39,8'h00,1'b1,1'b0, 8'd9},  // R9 R10 engine wins
      '{1'b0,1'b0,1'b1,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h39,8'h00,1'b0,1'b0, 8'd5},  // R5
      '{1'b0,1'b0,1'b0,8'h00,4'b0000,1'b0,4'h0,1'b1,8'h40,1'b0, 8'h39,8'h40,1'b0,1'b1, 8'd11}, // R11 engine count
      '{1'b1,1'b1,1'b0,8'h12,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h39,8'h40,1'b0,1'b1, 8'd4},  // R4 count locked
      '{1'b1,1'b0,1'b1,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h39,8'h40,1'b0,1'b0, 8'd5},  // R5
      '{1'b1,1'b1,1'b0,8'h12,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h39,8'h12,1'b0,1'b0, 8'd11}, // R11 cpu count
      '{1'b0,1'b0,1'b0,8'h00,4'b1000,1'b0,4'h0,1'b0,8'h00,1'b1, 8'hB9,8'h12,1'b1,1'b0, 8'd2},  // R2 setup
      '{1'b0,1'b0,1'b1,8'h00,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b1, 8'hB9,8'h12,1'b0,1'b0, 8'd5},  // R5
      '{1'b0,1'b1,1'b0,8'h02,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b1, 8'h82,8'h12,1'b0,1'b0, 8'd7},  // R7 pinned
      '{1'b0,1'b1,1'b0,8'h04,4'b0000,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h04,8'h12,1'b0,1'b0, 8'd6},  // R6
      '{1'b0,1'b0,1'b0,8'h00,4'b0001,1'b0,4'h0,1'b0,8'h00,1'b0, 8'h14,8'h12,1'b1,1'b0, 8'd3}   // R3 ACK only
   };

   task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      {cpu_sel, cpu_wr, cpu_rd, cpu_wdata, cpu_fifo_wr} = '0;
      {sie_setup_rx, sie_in_acked, sie_out_acked, sie_txn_acked} = '0;
      {sie_mode_we, sie_mode, sie_cnt_we, sie_cnt, sie_setup_pin} = '0;
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      clear_in();
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1", {mode_q, count_q, mode_locked, count_locked},
            {8'h00, 8'h00, 1'b0, 1'b0});
      check("R1", {17'd0, fifo_wr_en}, 18'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         cpu_sel = VEC[i].sel; cpu_wr = VEC[i].wr; cpu_rd = VEC[i].rd;
         cpu_wdata = VEC[i].wd;
         {sie_setup_rx, sie_in_acked, sie_out_acked, sie_txn_acked} = VEC[i].ev;
         sie_mode_we = VEC[i].mwe; sie_mode = VEC[i].mv;
         sie_cnt_we = VEC[i].cwe; sie_cnt = VEC[i].cv;
         sie_setup_pin = VEC[i].pin;
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[i].req, i),
               {mode_q, count_q, mode_locked, count_locked},
               {VEC[i].em, VEC[i].ec, VEC[i].ml, VEC[i].cl});
      end
      clear_in();

      // R8: flag clear, request passes
      cpu_fifo_wr = 1'b1;
      #1;
      check("R8 open", {17'd0, fifo_wr_en}, 18'd1);
      // R8: setup flag set, request blocked
      sie_setup_rx = 1'b1;
      @(negedge clk);
      sie_setup_rx = 1'b0;
      check("R8 blocked", {17'd0, fifo_wr_en}, 18'd0);
      check("R2 setup bit", {10'd0, mode_q}, {10'd0, 8'h94});
      // R5 read through data port, then R6 clear reopens gate
      cpu_rd = 1'b1; cpu_sel = 1'b0;
      #1;
      check("R5 rdata", {10'd0, cpu_rdata}, {10'd0, 8'h94});
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'hF7;
      @(negedge clk);
      cpu_wr = 1'b0;
      check("R6 reopen", {mode_q, 9'd0, fifo_wr_en}, {8'h07, 9'd0, 1'b1});

      // R1 reset mid-run
      sie_cnt_we = 1'b1; sie_cnt = 8'h77;
      @(negedge clk);
      clear_in();
      rst_n = 1'b0;
      #1;
      check("R1 rerst", {mode_q, count_q, mode_locked, count_locked}, 18'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule